// File: doc/BRIEF.md
# Sixteen-bit arithmetic and logic unit with a packed flags word

This block carries out one integer operation per clock on two operands, either on the full 16 bits or on the low byte alone. The eight operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare. The result goes into a result register. Six status flags (carry, parity, auxiliary carry, zero, sign, overflow) are derived from the operation and packed into a 16-bit flags register. That register also holds three control flags (trap, interrupt enable, direction). The control flags change only through a separate direct-load port.

An execution unit drives the operands, the operation code and the width select, and pulses `exec_en`. One clock edge later the result and the updated flags appear on the outputs. The carry-using operations take their carry-in from the flag currently held. Compare sets the flags exactly as subtract would, but it leaves the result register untouched. A control-flag load may land in the same cycle as an operation, and both take effect.

Top module: `alu16_flags`

## Requirements
- R1: The flags word places CF at bit 0, PF at bit 2, AF at bit 4, ZF at bit 6, SF at bit 7, TF at bit 8, IF at bit 9, DF at bit 10 and OF at bit 11. Every other bit always reads 0.
- R2: `op_sel` encodes 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare. On a clock edge with `exec_en` high, `result` and the status flags take the new values, and they are visible after that edge.
- R3: With `byte_mode` high, only the low 8 bits of each operand are used, `result[15:8]` is 0, and CF, OF, SF and ZF refer to an 8-bit result (sign at bit 7). With `byte_mode` low they refer to all 16 bits (sign at bit 15).
- R4: CF is the carry out of an add, or the borrow of a subtract. Add-with-carry adds the CF held before the edge, and subtract-with-borrow subtracts it.
- R5: AF is the carry or borrow out of bit 3 for arithmetic operations and compare. It is 0 after AND, OR and XOR.
- R6: PF is 1 when the low 8 bits of the result contain an even number of ones. ZF is 1 when the result at the selected width is zero. SF copies the result's sign bit.
- R7: OF is 1 when the two's-complement result falls outside -128..127 in byte mode, or outside -32768..32767 in word mode.
- R8: AND, OR and XOR clear CF and OF.
- R9: Compare updates the status flags exactly as subtract would, and it leaves `result` unchanged.
- R10: The control flags change only when `ctl_wr` is high: `ctl_val[0]` is loaded into TF, `ctl_val[1]` into IF, `ctl_val[2]` into DF. When `exec_en` is low, `result` and the status flags hold.
- R11: When `exec_en` and `ctl_wr` are high in the same cycle, the status flags come from the operation and the control flags from `ctl_val`, with no interference between them.
- R12: While `rst_n` is low, `result` and `flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | First operand (minuend for subtract and compare) |
| op_b | input | 16 | Second operand |
| op_sel | input | 3 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit |
| exec_en | input | 1 | Perform the selected operation on this edge |
| ctl_wr | input | 1 | Load the control flags on this edge |
| ctl_val | input | 3 | New control flags {DF, IF, TF} |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flags word |

## Verification
An operation and a direct load of the control flags can fall in the same cycle, and both write the one flags register. The random stimulus raises `ctl_wr` in about a fifth of the cycles, independently of `exec_en`, and one directed step forces both together. Every cycle is judged by comparing the whole flags word against a bench model. That model takes the status bits from the operation and the control bits from `ctl_val`, so a load that swallows the status update, or an operation that disturbs TF, IF or DF, is caught.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   localparam int FLAG_W = 16;
   localparam int FB_CF  = 0;
   localparam int FB_PF  = 2;
   localparam int FB_AF  = 4;
   localparam int FB_ZF  = 6;
   localparam int FB_SF  = 7;
   localparam int FB_TF  = 8;
   localparam int FB_IF  = 9;
   localparam int FB_DF  = 10;
   localparam int FB_OF  = 11;

   localparam logic [FLAG_W-1:0] FLAG_USED_MASK = 16'h0FD5;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } stat_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
   import alu16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   input  logic              narrow,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              aux,
   output logic              ovf
);
   localparam int NIB_W = 4;

   logic              is_sub;
   logic              is_logic;
   logic              c_use;
   logic [DATA_W:0]   wide;
   logic [NARROW_W:0] slim;
   logic [NIB_W:0]    nib;
   logic [DATA_W-1:0] lg;
   logic              sa, sb, sr;

   always_comb begin
      is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
      is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
      c_use    = ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0;
   end

   always_comb begin
      if (is_sub) begin
         wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, c_use};
         slim = {1'b0, a[NARROW_W-1:0]} - {1'b0, b[NARROW_W-1:0]} - {{NARROW_W{1'b0}}, c_use};
         nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, c_use};
      end else begin
         wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, c_use};
         slim = {1'b0, a[NARROW_W-1:0]} + {1'b0, b[NARROW_W-1:0]} + {{NARROW_W{1'b0}}, c_use};
         nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_use};
      end
   end

   always_comb begin
      case (op)
         OP_AND:  lg = a & b;
         OP_OR:   lg = a | b;
         default: lg = a ^ b;
      endcase
   end

   always_comb begin
      if (is_logic) begin
         res = narrow ? {{(DATA_W-NARROW_W){1'b0}}, lg[NARROW_W-1:0]} : lg;
      end else begin
         res = narrow ? {{(DATA_W-NARROW_W){1'b0}}, slim[NARROW_W-1:0]} : wide[DATA_W-1:0];
      end
   end

   always_comb begin
      sa = narrow ? a[NARROW_W-1] : a[DATA_W-1];
      sb = narrow ? b[NARROW_W-1] : b[DATA_W-1];
      sr = narrow ? slim[NARROW_W-1] : wide[DATA_W-1];
      if (is_logic) begin
         carry = 1'b0;
         aux   = 1'b0;
         ovf   = 1'b0;
      end else begin
         carry = narrow ? slim[NARROW_W] : wide[DATA_W];
         aux   = nib[NIB_W];
         ovf   = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
      end
   end

endmodule

// File: rtl/alu16_flaggen.sv
module alu16_flaggen
   import alu16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              narrow,
   input  logic              carry,
   input  logic              aux,
   input  logic              ovf,
   output stat_t             st
);
   logic [NARROW_W:0] par_chain;

   assign par_chain[0] = 1'b0;
   for (genvar i = 0; i < NARROW_W; i++) begin : g_par
      assign par_chain[i+1] = par_chain[i] ^ res[i];
   end

   always_comb begin
      st.cf = carry;
      st.af = aux;
      st.of = ovf;
      st.pf = ~par_chain[NARROW_W];
      st.zf = narrow ? (res[NARROW_W-1:0] == '0) : (res == '0);
      st.sf = narrow ? res[NARROW_W-1] : res[DATA_W-1];
   end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
   import alu16_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CTL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [2:0]        op_sel,
   input  logic              byte_mode,
   input  logic              exec_en,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_val,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   initial begin
      assert (DATA_W == FLAG_W) else $error("DATA_W must equal the flags word width");
      assert (NARROW_W == 8) else $error("NARROW_W must be 8");
      assert (CTL_W == 3) else $error("three control flags expected");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] core_res;
   logic              core_c, core_a, core_o;
   stat_t             st_next;
   logic [DATA_W-1:0] res_q;
   logic [FLAG_W-1:0] fl_q;

   assign op = alu_op_e'(op_sel);

   alu16_arith #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_arith (
      .a      (op_a),
      .b      (op_b),
      .op     (op),
      .narrow (byte_mode),
      .cin    (fl_q[FB_CF]),
      .res    (core_res),
      .carry  (core_c),
      .aux    (core_a),
      .ovf    (core_o)
   );

   alu16_flaggen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flg (
      .res    (core_res),
      .narrow (byte_mode),
      .carry  (core_c),
      .aux    (core_a),
      .ovf    (core_o),
      .st     (st_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (exec_en && (op != OP_CMP)) begin
         res_q <= core_res;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q <= '0;
      end else begin
         if (exec_en) begin
            fl_q[FB_CF] <= st_next.cf;
            fl_q[FB_PF] <= st_next.pf;
            fl_q[FB_AF] <= st_next.af;
            fl_q[FB_ZF] <= st_next.zf;
            fl_q[FB_SF] <= st_next.sf;
            fl_q[FB_OF] <= st_next.of;
         end
         if (ctl_wr) begin
            fl_q[FB_TF] <= ctl_val[0];
            fl_q[FB_IF] <= ctl_val[1];
            fl_q[FB_DF] <= ctl_val[2];
         end
      end
   end

   assign result = res_q;
   assign flags  = fl_q;

   // Assertions
   assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~FLAG_USED_MASK) == '0);

   assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(flags[FB_DF:FB_TF]));

   assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> ($stable(result) && $stable(flags & ~16'h0700)));

   assert_cmp_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == OP_CMP) |=> $stable(result));

   assert_byte_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && byte_mode && op != OP_CMP) |=> (result[DATA_W-1:NARROW_W] == '0));

   assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
         (!flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF]));

   assert_ctl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (flags[FB_DF:FB_TF] == $past(ctl_val)));

endmodule

// File: tb/alu16_flags_test.sv
`timescale 1ns/1ps
module alu16_flags_test;
   logic        clk;
   logic        rst_n;
   logic [15:0] op_a, op_b;
   logic [2:0]  op_sel;
   logic        byte_mode, exec_en, ctl_wr;
   logic [2:0]  ctl_val;
   logic [15:0] result, flags;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_res, exp_fl;

   alu16_flags uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .byte_mode(byte_mode), .exec_en(exec_en), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
      .result(result), .flags(flags)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   function automatic int sval(int x, int width_bits);
      int half;
      half = 1 << (width_bits - 1);
      return (x >= half) ? x - 2 * half : x;
   endfunction

   // Independent reference of R1..R11
   function automatic void model(int op, int a, int b, bit bm, bit ex, bit cw, logic [2:0] cv);
      int mask, wb, aa, bb, c, full, r, sres;
      bit cf, af, of, zf, sf, pf;
      mask = bm ? 'hFF : 'hFFFF;
      wb   = bm ? 8 : 16;
      aa = a & mask;
      bb = b & mask;
      c  = (op == 1 || op == 3) ? int'(exp_fl[0]) : 0;
      cf = 0; af = 0; of = 0;
      if (op == 0 || op == 1) begin
         full = aa + bb + c;
         r  = full & mask;
         cf = full > mask;
         af = ((aa & 15) + (bb & 15) + c) > 15;
         sres = sval(aa, wb) + sval(bb, wb) + c;
         of = (sres >= (1 << (wb - 1))) || (sres < -(1 << (wb - 1)));
      end else if (op == 2 || op == 3 || op == 7) begin
         full = aa - bb - c;
         r  = full & mask;
         cf = full < 0;
         af = ((aa & 15) - (bb & 15) - c) < 0;
         sres = sval(aa, wb) - sval(bb, wb) - c;
         of = (sres >= (1 << (wb - 1))) || (sres < -(1 << (wb - 1)));
      end else if (op == 4) r = aa & bb;
      else if (op == 5) r = aa | bb;
      else r = aa ^ bb;
      zf = (r == 0);
      sf = (r >> (wb - 1)) & 1;
      pf = ~^r[7:0];
      if (ex) begin
         if (op != 7) exp_res = r[15:0];
         exp_fl[0] = cf; exp_fl[2] = pf; exp_fl[4] = af;
         exp_fl[6] = zf; exp_fl[7] = sf; exp_fl[11] = of;
      end
      if (cw) exp_fl[10:8] = {cv[2], cv[1], cv[0]};
   endfunction

   task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run(int op, int a, int b, bit bm, bit ex, bit cw, logic [2:0] cv, string req);
      op_a = a[15:0]; op_b = b[15:0]; op_sel = op[2:0];
      byte_mode = bm; exec_en = ex; ctl_wr = cw; ctl_val = cv;
      @(posedge clk);
      #1;
      model(op, a, b, bm, ex, cw, cv);
      exec_en = 0; ctl_wr = 0;
      check16(req, "result", result, exp_res);
      check16(req, "flags", flags, exp_fl);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h1BADF00D;
      void'($urandom(seed));
      rst_n = 0; op_a = 0; op_b = 0; op_sel = 0; byte_mode = 0;
      exec_en = 0; ctl_wr = 0; ctl_val = 0;
      exp_res = 0; exp_fl = 0;
      repeat (3) @(posedge clk);
      #1;
      check16("R12", "reset result", result, 16'h0000);
      check16("R12", "reset flags", flags, 16'h0000);
      rst_n = 1;

      run(0, 'h7FFF, 'h0001, 0, 1, 0, 0, "R7 word add overflow");      // 8000, OF SF AF
      run(0, 'hFFFF, 'h0001, 0, 1, 0, 0, "R4 word carry zero");        // 0000, CF ZF PF AF
      run(1, 'h0001, 'h0001, 0, 1, 0, 0, "R4 adc uses CF");            // 0003
      run(0, 'h1280, 'h3480, 1, 1, 0, 0, "R3 byte add carry");         // 0000 CF OF ZF
      run(2, 'h0000, 'h0001, 0, 1, 0, 0, "R4 R5 sub borrow");          // FFFF CF AF SF
      run(3, 'h0005, 'h0002, 1, 1, 0, 0, "R4 sbb uses CF");            // 0002
      run(2, 'h0080, 'h0001, 1, 1, 0, 0, "R7 byte sub overflow");      // 7F OF AF
      run(4, 'hF0F0, 'h0FF0, 0, 1, 0, 0, "R8 and clears CF OF");
      run(6, 'hAAAA, 'hAAAA, 0, 1, 0, 0, "R6 xor zero parity");
      run(5, 'h0100, 'h0001, 1, 1, 0, 0, "R6 byte or ignores high");
      run(7, 'h0010, 'h0020, 0, 1, 0, 0, "R9 cmp keeps result");
      run(0, 'h0000, 'h0000, 0, 0, 1, 3'b101, "R10 ctl load only");
      run(2, 'h1234, 'h1234, 0, 0, 0, 0, "R10 no exec holds");
      run(0, 'h000F, 'h0001, 0, 1, 1, 3'b010, "R11 exec and ctl together");
      run(0, 'h4000, 'h4000, 0, 1, 0, 0, "R1 R2 layout after add");

      for (int i = 0; i < 400; i++) begin
         int op, a, b;
         bit bm, ex, cw;
         logic [2:0] cv;
         op = int'($urandom_range(7, 0));
         a  = int'($urandom_range(16'hFFFF, 0));
         b  = int'($urandom_range(16'hFFFF, 0));
         if ($urandom_range(9, 0) == 0) a = 'h8000;
         if ($urandom_range(9, 0) == 0) b = a;
         bm = $urandom_range(1, 0) == 1;
         ex = $urandom_range(9, 0) < 8;
         cw = $urandom_range(4, 0) == 0;
         cv = 3'($urandom_range(7, 0));
         run(op, a, b, bm, ex, cw, cv, "R2 R3 R4 R5 R6 R7 R11 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule